// File: doc/BRIEF.md
# Halfword Access Sequencer

This block sits between a host that issues 16-bit and 32-bit accesses and a local port that is only 16 bits wide. Each host request is turned into one or two local halfword accesses, and the block returns a single completion to the host. Memory space and register space split a 32-bit access differently. In memory space, a double word is two halfwords at consecutive local addresses. In register space, only the lower halfword is used.

The host holds a request (valid, write flag, space select, halfword address, byte enables, write data) until the block raises ready for one cycle. The local side uses separate read and write strobes. Each strobe stays high, with its address and data unchanged, until the local acknowledge input is seen. Byte writes never reach the local port. They complete at once on the host side and set an error flag that stays set until reset.

Top module: `halfword_access_seq`

## Requirements
- R1: After reset, `req_ready`, `loc_rd`, `loc_wr` and `err_flag` are all 0.
- R2: The access size comes only from the number of set bits in `req_be`. Four set bits mean 32-bit, exactly two mean 16-bit, and any other count means byte. Which lanes are set has no further effect.
- R3: A 32-bit read with `req_space`=0 (memory) does two local reads. The first is at `req_addr` and the second at `req_addr`+1, wrapping modulo 2^ADDR_W. The result is `rsp_rdata` = {second word, first word}.
- R4: A 32-bit read with `req_space`=1 (register) does exactly one local read at `req_addr`. `rsp_rdata[15:0]` is that word and `rsp_rdata[31:16]` is 0.
- R5: A 16-bit read and a byte read each do exactly one local read at `req_addr`. The result carries the full 16-bit word in `rsp_rdata[15:0]` and 0 in `rsp_rdata[31:16]`.
- R6: A 32-bit write in memory space does two local writes: `req_wdata[15:0]` to `req_addr`, then `req_wdata[31:16]` to `req_addr`+1.
- R7: A 32-bit write in register space and any 16-bit write each do exactly one local write, of `req_wdata[15:0]` to `req_addr`.
- R8: A byte write raises no local strobe and still completes with `req_ready`. It sets `err_flag`, which then stays 1 until reset, through later legal accesses.
- R9: Each local strobe, with its address and write data, is held unchanged until a cycle in which `loc_ack` is 1. That cycle ends the sub-access. No sub-access is repeated or skipped, whatever the number of wait cycles.
- R10: `req_ready` is a one-cycle pulse in the cycle after the last local acknowledge, with `rsp_rdata` valid in that cycle. `loc_rd` and `loc_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = memory space, 1 = register space |
| req_addr | input | ADDR_W | Halfword address |
| req_be | input | HDATA_W/8 | Byte enables, used only for size |
| req_wdata | input | HDATA_W | Host write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | HDATA_W | Read result, valid with req_ready |
| err_flag | output | 1 | Sticky rejected-byte-write flag |
| loc_rd | output | 1 | Local read strobe |
| loc_wr | output | 1 | Local write strobe |
| loc_addr | output | ADDR_W | Local halfword address |
| loc_wdata | output | LDATA_W | Local write data |
| loc_rdata | input | LDATA_W | Local read data |
| loc_ack | input | 1 | Local sub-access done |

## Verification
The bench targets the memory-space double word at the top address. A design that got the wrap wrong would issue its second read at an address beyond the port range, or would swap the halves in the packed result. A register-space double word read is checked for a single access and a zero upper half, which exposes a design that split it like memory or left stale data in the upper half. Byte writes are checked for a missing local strobe and for an error flag that survives later legal accesses. Long acknowledge delays expose any design that moves the address early or issues a sub-access twice.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_DONE = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic write;
      logic two_part;
      logic reject;
   } op_plan_t;

endpackage

// File: rtl/hwseq_decode.sv
module hwseq_decode
   import hwseq_pkg::*;
#(
   parameter int BE_W = 4
) (
   input  logic [BE_W-1:0] be,
   input  logic            write,
   input  logic            space,
   output acc_size_e       size,
   output op_plan_t        plan
);
   localparam int CNT_W = $clog2(BE_W + 1);

   generate
      if (BE_W != 4) begin : g_bad_be
         $error("hwseq_decode: byte enable width must be 4");
      end
   endgenerate

   logic [CNT_W-1:0] be_cnt;

   always_comb begin
      be_cnt = '0;
      for (int i = 0; i < BE_W; i++) begin
         be_cnt = be_cnt + CNT_W'(be[i]);
      end
   end

   always_comb begin
      if (be_cnt == CNT_W'(BE_W))           size = SZ_WORD;
      else if (be_cnt == CNT_W'(BE_W / 2))  size = SZ_HALF;
      else                                  size = SZ_BYTE;
   end

   always_comb begin
      plan.write    = write;
      plan.two_part = (size == SZ_WORD) && !space;
      plan.reject   = write && (size == SZ_BYTE);
   end

endmodule

// File: rtl/hwseq_fsm.sv
module hwseq_fsm
   import hwseq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  op_plan_t plan,
   input  logic     loc_ack,
   output logic     latch_en,
   output logic     cap_lo,
   output logic     cap_hi,
   output logic     phase_hi,
   output logic     loc_rd,
   output logic     loc_wr,
   output logic     req_ready,
   output logic     err_flag
);
   seq_state_e st;
   op_plan_t   pl_q;
   logic       in_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         pl_q     <= '0;
         err_flag <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               pl_q <= plan;
               if (plan.reject) begin
                  err_flag <= 1'b1;
                  st       <= ST_DONE;
               end else begin
                  st <= ST_LO;
               end
            end
            ST_LO: if (loc_ack) st <= pl_q.two_part ? ST_HI : ST_DONE;
            ST_HI: if (loc_ack) st <= ST_DONE;
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      in_acc    = (st == ST_LO) || (st == ST_HI);
      loc_rd    = in_acc && !pl_q.write;
      loc_wr    = in_acc && pl_q.write;
      phase_hi  = (st == ST_HI);
      latch_en  = (st == ST_IDLE) && req_valid;
      cap_lo    = (st == ST_LO) && loc_ack;
      cap_hi    = (st == ST_HI) && loc_ack;
      req_ready = (st == ST_DONE);
   end

   // R10: the two strobes never overlap
   a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_rd && loc_wr));

   // R9: a strobe without acknowledge is still present next cycle
   a_r9_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((loc_rd || loc_wr) && !loc_ack) |=> (loc_rd || loc_wr));

   // R10: completion is a single-cycle pulse
   a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R8: the error flag never clears once set
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

endmodule

// File: rtl/hwseq_datapath.sv
module hwseq_datapath #(
   parameter int ADDR_W  = 16,
   parameter int LDATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   latch_en,
   input  logic                   cap_lo,
   input  logic                   cap_hi,
   input  logic                   phase_hi,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [2*LDATA_W-1:0]   req_wdata,
   input  logic [LDATA_W-1:0]     loc_rdata,
   output logic [ADDR_W-1:0]      loc_addr,
   output logic [LDATA_W-1:0]     loc_wdata,
   output logic [2*LDATA_W-1:0]   rsp_rdata
);
   localparam int HDATA_W = 2 * LDATA_W;

   logic [ADDR_W-1:0]  addr_q;
   logic [HDATA_W-1:0] wdata_q;
   logic [LDATA_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         if (latch_en) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            lo_q    <= '0;
            hi_q    <= '0;
         end
         if (cap_lo) lo_q <= loc_rdata;
         if (cap_hi) hi_q <= loc_rdata;
      end
   end

   always_comb begin
      loc_addr  = phase_hi ? addr_q + ADDR_W'(1) : addr_q;
      loc_wdata = phase_hi ? wdata_q[HDATA_W-1:LDATA_W] : wdata_q[LDATA_W-1:0];
      rsp_rdata = {hi_q, lo_q};
   end

endmodule

// File: rtl/halfword_access_seq.sv
module halfword_access_seq
   import hwseq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int LDATA_W = 16,
   parameter int HDATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic                 req_space,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [HDATA_W/8-1:0] req_be,
   input  logic [HDATA_W-1:0]   req_wdata,
   output logic                 req_ready,
   output logic [HDATA_W-1:0]   rsp_rdata,
   output logic                 err_flag,
   output logic                 loc_rd,
   output logic                 loc_wr,
   output logic [ADDR_W-1:0]    loc_addr,
   output logic [LDATA_W-1:0]   loc_wdata,
   input  logic [LDATA_W-1:0]   loc_rdata,
   input  logic                 loc_ack
);
   localparam int BE_W = HDATA_W / 8;

   generate
      if (HDATA_W != 2 * LDATA_W) begin : g_bad_width
         $error("halfword_access_seq: host width must be twice the local width");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("halfword_access_seq: address too narrow");
      end
   endgenerate

   acc_size_e size;
   op_plan_t  plan;
   logic      latch_en, cap_lo, cap_hi, phase_hi;

   hwseq_decode #(.BE_W(BE_W)) u_dec (
      .be    (req_be),
      .write (req_write),
      .space (req_space),
      .size  (size),
      .plan  (plan)
   );

   hwseq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .plan      (plan),
      .loc_ack   (loc_ack),
      .latch_en  (latch_en),
      .cap_lo    (cap_lo),
      .cap_hi    (cap_hi),
      .phase_hi  (phase_hi),
      .loc_rd    (loc_rd),
      .loc_wr    (loc_wr),
      .req_ready (req_ready),
      .err_flag  (err_flag)
   );

   hwseq_datapath #(.ADDR_W(ADDR_W), .LDATA_W(LDATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_en  (latch_en),
      .cap_lo    (cap_lo),
      .cap_hi    (cap_hi),
      .phase_hi  (phase_hi),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .loc_rdata (loc_rdata),
      .loc_addr  (loc_addr),
      .loc_wdata (loc_wdata),
      .rsp_rdata (rsp_rdata)
   );

   // R9: address and write data hold while a sub-access waits
   a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ((loc_rd || loc_wr) && !loc_ack) |=> ($stable(loc_addr) && $stable(loc_wdata)));

   // R3: the upper sub-access targets the next halfword address
   a_r3_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_hi) |-> (loc_addr == $past(loc_addr) + ADDR_W'(1)));

   // R8: a rejected write raises no write strobe before it completes
   a_r8_no_byte_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !loc_rd && !loc_wr && plan.reject) |=> !loc_wr);

endmodule

// File: tb/tb_halfword_access_seq.sv
module tb_halfword_access_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_space = 1'b0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, err_flag, loc_rd, loc_wr;
   logic [31:0] rsp_rdata;
   logic [15:0] loc_addr, loc_wdata;
   logic [15:0] loc_rdata = '0;
   logic        loc_ack = 1'b0;

   int n_run = 0, n_fail = 0, wait_n = 0, wdog = 0, wcnt = 0, hold_viol = 0;
   int log_n = 0;
   logic [15:0] log_addr [64];
   logic [15:0] log_data [64];
   logic        log_wr   [64];
   logic        prev_strobe = 1'b0, prev_ack = 1'b0;
   logic [15:0] prev_addr = '0;

   always #2.5 clk = ~clk;

   halfword_access_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_space(req_space), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
      .err_flag(err_flag), .loc_rd(loc_rd), .loc_wr(loc_wr),
      .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .loc_ack(loc_ack)
   );

   function automatic logic [15:0] mem_val(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h3C5A;
   endfunction

   // local port model: acknowledges after wait_n extra cycles
   always @(negedge clk) begin
      if ((loc_rd || loc_wr) && prev_strobe && !prev_ack && loc_addr != prev_addr)
         hold_viol++;
      prev_strobe = loc_rd || loc_wr;
      prev_addr   = loc_addr;
      if (loc_ack) begin
         loc_ack = 1'b0;
         wcnt    = 0;
      end else if (loc_rd || loc_wr) begin
         if (wcnt >= wait_n) begin
            loc_ack   = 1'b1;
            loc_rdata = mem_val(loc_addr);
            log_addr[log_n % 64] = loc_addr;
            log_data[log_n % 64] = loc_wr ? loc_wdata : mem_val(loc_addr);
            log_wr[log_n % 64]   = loc_wr;
            log_n++;
         end else begin
            wcnt++;
         end
      end
      prev_ack = loc_ack;
   end

   always @(posedge clk) begin
      wdog++;
      if (wdog > 100000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_acc(input logic wr, input logic sp, input logic [15:0] a,
                          input logic [3:0] be, input logic [31:0] wd,
                          output logic [31:0] rd, output int base);
      int t;
      base = log_n;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_space = sp;
      req_addr = a; req_be = be; req_wdata = wd;
      t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!req_ready && t < 300);
      chk(req_ready, "R10 completion seen", {31'd0, req_ready}, 32'd1);
      rd = rsp_rdata;
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(!req_ready && !loc_rd && !loc_wr && !err_flag, "R1 reset outputs",
          {28'd0, req_ready, loc_rd, loc_wr, err_flag}, 32'd0);
   endtask

   task automatic t_mem_read32(input logic [15:0] a, input int w);
      logic [31:0] rd; int b;
      logic [15:0] a1;
      a1 = a + 16'd1;
      wait_n = w;
      run_acc(1'b0, 1'b0, a, 4'b1111, 32'd0, rd, b);
      chk(log_n - b == 2, "R3 two local reads", log_n - b, 2);
      chk(log_addr[b % 64] == a && log_addr[(b + 1) % 64] == a1, "R3 read order",
          {log_addr[b % 64], log_addr[(b + 1) % 64]}, {a, a1});
      chk(rd == {mem_val(a1), mem_val(a)}, "R3 packed data", rd, {mem_val(a1), mem_val(a)});
   endtask

   task automatic t_reg_read32();
      logic [31:0] rd; int b;
      wait_n = 1;
      run_acc(1'b0, 1'b1, 16'h0040, 4'b1111, 32'd0, rd, b);
      chk(log_n - b == 1, "R4 single read", log_n - b, 1);
      chk(rd == {16'd0, mem_val(16'h0040)}, "R4 zero upper half", rd, {16'd0, mem_val(16'h0040)});
   endtask

   task automatic t_narrow_read(input logic [3:0] be, input logic sp, input string req);
      logic [31:0] rd; int b;
      wait_n = 0;
      run_acc(1'b0, sp, 16'h1234, be, 32'd0, rd, b);
      chk(log_n - b == 1 && !log_wr[b % 64] && log_addr[b % 64] == 16'h1234, req,
          log_n - b, 1);
      chk(rd == {16'd0, mem_val(16'h1234)}, req, rd, {16'd0, mem_val(16'h1234)});
   endtask

   task automatic t_mem_write32();
      logic [31:0] rd; int b;
      wait_n = 2;
      run_acc(1'b1, 1'b0, 16'h0200, 4'b1111, 32'hBEEF_CAFE, rd, b);
      chk(log_n - b == 2, "R6 two local writes", log_n - b, 2);
      chk(log_wr[b % 64] && log_addr[b % 64] == 16'h0200 && log_data[b % 64] == 16'hCAFE,
          "R6 lower half first", {log_addr[b % 64], log_data[b % 64]}, {16'h0200, 16'hCAFE});
      chk(log_wr[(b + 1) % 64] && log_addr[(b + 1) % 64] == 16'h0201 &&
          log_data[(b + 1) % 64] == 16'hBEEF, "R6 upper half second",
          {log_addr[(b + 1) % 64], log_data[(b + 1) % 64]}, {16'h0201, 16'hBEEF});
   endtask

   task automatic t_single_write(input logic sp, input logic [3:0] be, input string req);
      logic [31:0] rd; int b;
      wait_n = 0;
      run_acc(1'b1, sp, 16'h0333, be, 32'h1111_2222, rd, b);
      chk(log_n - b == 1 && log_wr[b % 64] && log_addr[b % 64] == 16'h0333 &&
          log_data[b % 64] == 16'h2222, req, {log_addr[b % 64], log_data[b % 64]},
          {16'h0333, 16'h2222});
   endtask

   task automatic t_byte_write();
      logic [31:0] rd; int b;
      logic [31:0] rd2; int b2;
      chk(!err_flag, "R8 flag clear before", {31'd0, err_flag}, 32'd0);
      run_acc(1'b1, 1'b0, 16'h0050, 4'b0100, 32'hFFFF_FFFF, rd, b);
      chk(log_n == b, "R8 no local strobe", log_n - b, 0);
      chk(err_flag, "R8 error set", {31'd0, err_flag}, 32'd1);
      run_acc(1'b0, 1'b1, 16'h0007, 4'b0011, 32'd0, rd2, b2);
      chk(err_flag, "R8 error sticky", {31'd0, err_flag}, 32'd1);
   endtask

   task automatic t_ready_pulse();
      logic [31:0] rd; int b;
      wait_n = 0;
      run_acc(1'b0, 1'b0, 16'h0010, 4'b0011, 32'd0, rd, b);
      @(negedge clk);
      chk(!req_ready && !loc_rd && !loc_wr, "R10 ready one cycle",
          {30'd0, req_ready, loc_rd}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mem_read32(16'h0100, 0);
      t_mem_read32(16'hFFFF, 2);               // R3 wrap with waits
      t_mem_read32(16'h0A0A, 5);               // R9 long waits
      chk(hold_viol == 0, "R9 address held until ack", hold_viol, 0);
      t_reg_read32();
      t_narrow_read(4'b0011, 1'b0, "R5 16-bit read");
      t_narrow_read(4'b0001, 1'b0, "R5 byte read full word");
      t_narrow_read(4'b1100, 1'b1, "R2 16-bit by count, upper lanes");
      t_mem_write32();
      t_single_write(1'b1, 4'b1111, "R7 register 32-bit write");
      t_single_write(1'b0, 4'b1100, "R7 R2 16-bit write upper lanes");
      t_ready_pulse();
      t_byte_write();
      chk(hold_viol == 0, "R9 no early address change", hold_viol, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule